// File: doc/BRIEF.md
# Hierarchical Multi-Bank Match Engine

This block resolves a search key against a routing table whose entries sit at a few fixed levels of an address hierarchy. It holds several logical banks of binary content-addressable storage. Each bank has its own compare mask, and every word in a bank is compared only on the bits that mask keeps. A bank therefore holds the entries of one hierarchy depth. Bank 0 holds the most specific level, with the widest mask. Higher bank indices hold progressively coarser levels.

One search key is applied to all banks in the same cycle. Each bank reports whether it hit and returns the result byte of its matching word. A fixed-priority selector forwards only the most specific bank that hit, together with that bank's index. When no bank hits, a programmable default result is returned in its place, so every search produces exactly one answer. One edge registers the bank compares and the next edge registers the selection. The answer is therefore available one search cycle plus one read cycle after the key is presented.

Software programs the bank masks and the default through the configuration inputs. It places each entry in the bank for that entry's depth, where the entry takes the lowest free slot. It removes entries by key.

Top module: `hier_cam_lookup`

## Requirements
- R1: After a synchronous reset, res_valid, res_hit, res_bank, res_data and ins_err are 0, every bank is empty, every bank mask is all ones, and the default result is 0.
- R2: cfg_mask_we with cfg_bank = b loads cfg_mask into bank b's mask. An entry of bank b matches key k when (entry_key AND mask_b) equals (k AND mask_b).
- R3: srch_valid sampled at clock edge E searches all banks with srch_key. The outcome is visible on res_valid/res_hit/res_bank/res_data after edge E+1, and res_valid is high for exactly that cycle.
- R4: When more than one bank hits, the lowest-numbered bank wins. res_hit is 1, res_bank carries the winning bank index, and res_data carries the result byte of the matching entry.
- R5: When more than one valid entry of the same bank matches, the entry in the lowest slot index supplies res_data.
- R6: When no bank hits, res_hit is 0, res_bank is 0, and res_data equals the default result (loaded by cfg_dflt_we) that was in effect before edge E.
- R7: ins_valid writes ins_key/ins_data into the lowest free slot of bank ins_bank. If that bank is full, nothing is stored and ins_err is 1 for the one cycle after edge E. Otherwise ins_err is 0.
- R8: del_valid invalidates every valid entry of bank del_bank that matches del_key under that bank's mask. Freed slots are reused by later inserts.
- R9: A search at edge E sees the table, masks and default as they stood before E. Inserts, deletes and configuration writes sampled at the same edge affect only later searches. An insert and a delete to the same bank at the same edge both take effect.
- R10: In a cycle where res_valid is 0, res_hit, res_bank and res_data are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_mask_we | input | 1 | Load a bank mask |
| cfg_bank | input | 2 | Bank selected for the mask load |
| cfg_mask | input | 40 | Mask value, 1 = bit compared |
| cfg_dflt_we | input | 1 | Load the default result |
| cfg_dflt | input | 8 | Default result value |
| ins_valid | input | 1 | Insert an entry |
| ins_bank | input | 2 | Target bank of the insert |
| ins_key | input | 40 | Key of the inserted entry |
| ins_data | input | 8 | Result byte of the inserted entry |
| del_valid | input | 1 | Delete entries by key |
| del_bank | input | 2 | Bank of the delete |
| del_key | input | 40 | Key compared under the bank mask for deletion |
| srch_valid | input | 1 | Start a search |
| srch_key | input | 40 | Search key |
| res_valid | output | 1 | Search result present |
| res_hit | output | 1 | Some bank matched |
| res_bank | output | 2 | Index of the winning bank |
| res_data | output | 8 | Winning result byte or default |
| ins_err | output | 1 | Previous insert was rejected, bank full |

## Verification
A search and a table update can share an edge, and the interesting case is an insert of a key together with a search for that same key. Directed steps present both in one cycle and expect the old answer. They then repeat the search alone and expect the new entry. A same-edge default change and a same-edge insert into a full bank are handled the same way. The random phase mixes inserts, deletes and searches in every cycle. The bench model always resolves the search against the pre-edge table before it applies that cycle's writes, so any ordering slip shows up as a wrong bank or a wrong byte.

// File: rtl/hcam_pkg.sv
package hcam_pkg;
  localparam int HCAM_BANKS  = 3;
  localparam int HCAM_DEPTH  = 16;
  localparam int HCAM_KEY_W  = 40;
  localparam int HCAM_DATA_W = 8;
endpackage

// File: rtl/hcam_bank.sv
module hcam_bank #(
  parameter int DEPTH  = hcam_pkg::HCAM_DEPTH,
  parameter int KEY_W  = hcam_pkg::HCAM_KEY_W,
  parameter int DATA_W = hcam_pkg::HCAM_DATA_W,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mask_we,
  input  logic [KEY_W-1:0]  mask_in,
  input  logic              ins_en,
  input  logic [KEY_W-1:0]  ins_key,
  input  logic [DATA_W-1:0] ins_data,
  input  logic              del_en,
  input  logic [KEY_W-1:0]  del_key,
  input  logic              srch_en,
  input  logic [KEY_W-1:0]  srch_key,
  output logic              full,
  output logic              ins_rej,
  output logic              hit_q,
  output logic [DATA_W-1:0] data_q
);
  logic [KEY_W-1:0]  mask_q;
  logic [DEPTH-1:0]  valid_q;
  logic [KEY_W-1:0]  key_mem  [DEPTH];
  logic [DATA_W-1:0] data_mem [DEPTH];

  logic [DEPTH-1:0]  srch_match, del_match, ins_onehot;
  logic [IDX_W-1:0]  free_idx, first_idx;
  logic              ins_ok;

  // per-word compare under the bank mask
  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      srch_match[i] = valid_q[i] && (((key_mem[i] ^ srch_key) & mask_q) == '0);
      del_match[i]  = valid_q[i] && (((key_mem[i] ^ del_key) & mask_q) == '0);
    end
  end

  // lowest free slot and lowest matching slot
  always_comb begin
    free_idx  = '0;
    first_idx = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (!valid_q[i])   free_idx  = IDX_W'(i);
      if (srch_match[i]) first_idx = IDX_W'(i);
    end
  end

  assign full       = &valid_q;
  assign ins_ok     = ins_en && !full;
  assign ins_onehot = ins_ok ? (DEPTH'(1) << free_idx) : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q  <= '1;
      valid_q <= '0;
      hit_q   <= 1'b0;
      data_q  <= '0;
      ins_rej <= 1'b0;
    end else begin
      if (mask_we) mask_q <= mask_in;
      valid_q <= (valid_q & ~(del_en ? del_match : '0)) | ins_onehot;
      hit_q   <= srch_en && (|srch_match);
      data_q  <= (srch_en && (|srch_match)) ? data_mem[first_idx] : '0;
      ins_rej <= ins_en && full;
    end
  end

  // entry storage, no reset so it maps onto plain memory
  always_ff @(posedge clk) begin
    if (ins_ok) begin
      key_mem[free_idx]  <= ins_key;
      data_mem[free_idx] <= ins_data;
    end
  end
endmodule

// File: rtl/hcam_select.sv
module hcam_select #(
  parameter int NB     = hcam_pkg::HCAM_BANKS,
  parameter int DATA_W = hcam_pkg::HCAM_DATA_W,
  localparam int BANK_W = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              s1_valid,
  input  logic [NB-1:0]     hit_vec,
  input  logic [DATA_W-1:0] data_vec [NB],
  input  logic [DATA_W-1:0] s1_dflt,
  output logic              res_valid,
  output logic              res_hit,
  output logic [BANK_W-1:0] res_bank,
  output logic [DATA_W-1:0] res_data
);
  logic [BANK_W-1:0] win;
  logic              any_hit;

  always_comb begin
    win = '0;
    for (int b = NB - 1; b >= 0; b--)
      if (hit_vec[b]) win = BANK_W'(b);
  end
  assign any_hit = |hit_vec;

  always_ff @(posedge clk) begin
    if (rst || !s1_valid) begin
      res_valid <= 1'b0;
      res_hit   <= 1'b0;
      res_bank  <= '0;
      res_data  <= '0;
    end else begin
      res_valid <= 1'b1;
      res_hit   <= any_hit;
      res_bank  <= any_hit ? win : '0;
      res_data  <= any_hit ? data_vec[win] : s1_dflt;
    end
  end
endmodule

// File: rtl/hier_cam_lookup.sv
module hier_cam_lookup #(
  parameter int NB     = hcam_pkg::HCAM_BANKS,
  parameter int DEPTH  = hcam_pkg::HCAM_DEPTH,
  parameter int KEY_W  = hcam_pkg::HCAM_KEY_W,
  parameter int DATA_W = hcam_pkg::HCAM_DATA_W,
  localparam int BANK_W = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_mask_we,
  input  logic [BANK_W-1:0] cfg_bank,
  input  logic [KEY_W-1:0]  cfg_mask,
  input  logic              cfg_dflt_we,
  input  logic [DATA_W-1:0] cfg_dflt,
  input  logic              ins_valid,
  input  logic [BANK_W-1:0] ins_bank,
  input  logic [KEY_W-1:0]  ins_key,
  input  logic [DATA_W-1:0] ins_data,
  input  logic              del_valid,
  input  logic [BANK_W-1:0] del_bank,
  input  logic [KEY_W-1:0]  del_key,
  input  logic              srch_valid,
  input  logic [KEY_W-1:0]  srch_key,
  output logic              res_valid,
  output logic              res_hit,
  output logic [BANK_W-1:0] res_bank,
  output logic [DATA_W-1:0] res_data,
  output logic              ins_err
);
  logic [NB-1:0]     bank_full, bank_rej, bank_hit;
  logic [DATA_W-1:0] bank_data [NB];
  logic [DATA_W-1:0] dflt_q, s1_dflt;
  logic              s1_valid;

  for (genvar b = 0; b < NB; b++) begin : g_bank
    hcam_bank #(.DEPTH(DEPTH), .KEY_W(KEY_W), .DATA_W(DATA_W)) u_bank (
      .clk      (clk),
      .rst      (rst),
      .mask_we  (cfg_mask_we && (cfg_bank == BANK_W'(b))),
      .mask_in  (cfg_mask),
      .ins_en   (ins_valid && (ins_bank == BANK_W'(b))),
      .ins_key  (ins_key),
      .ins_data (ins_data),
      .del_en   (del_valid && (del_bank == BANK_W'(b))),
      .del_key  (del_key),
      .srch_en  (srch_valid),
      .srch_key (srch_key),
      .full     (bank_full[b]),
      .ins_rej  (bank_rej[b]),
      .hit_q    (bank_hit[b]),
      .data_q   (bank_data[b])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dflt_q   <= '0;
      s1_dflt  <= '0;
      s1_valid <= 1'b0;
    end else begin
      if (cfg_dflt_we) dflt_q <= cfg_dflt;
      s1_valid <= srch_valid;
      s1_dflt  <= dflt_q;
    end
  end

  assign ins_err = |bank_rej;

  hcam_select #(.NB(NB), .DATA_W(DATA_W)) u_sel (
    .clk       (clk),
    .rst       (rst),
    .s1_valid  (s1_valid),
    .hit_vec   (bank_hit),
    .data_vec  (bank_data),
    .s1_dflt   (s1_dflt),
    .res_valid (res_valid),
    .res_hit   (res_hit),
    .res_bank  (res_bank),
    .res_data  (res_data)
  );
endmodule

// File: rtl/hier_cam_lookup_chk.sv
module hier_cam_lookup_chk #(
  parameter int NB     = 3,
  parameter int DATA_W = 8,
  parameter int BANK_W = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              srch_valid,
  input logic              ins_valid,
  input logic [BANK_W-1:0] ins_bank,
  input logic [NB-1:0]     bank_full,
  input logic              res_valid,
  input logic              res_hit,
  input logic [BANK_W-1:0] res_bank,
  input logic [DATA_W-1:0] res_data,
  input logic              ins_err
);
  // R3: a search yields a result two edges later, and only then
  p_latency_r3: assert property (@(posedge clk) disable iff (rst)
    srch_valid |-> ##2 res_valid);
  p_no_orphan_r3: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> $past(srch_valid, 2));
  // R4: winning bank index is a real bank
  p_bank_range_r4: assert property (@(posedge clk) disable iff (rst)
    res_hit |-> (res_bank < BANK_W'(NB)));
  // R6: a miss reports bank 0
  p_miss_bank_r6: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !res_hit) |-> (res_bank == '0));
  // R7: insert into a full bank is flagged next cycle; flag needs an insert
  p_full_reject_r7: assert property (@(posedge clk) disable iff (rst)
    (ins_valid && (ins_bank < BANK_W'(NB)) && bank_full[ins_bank]) |=> ins_err);
  p_err_cause_r7: assert property (@(posedge clk) disable iff (rst)
    ins_err |-> $past(ins_valid));
  // R10: quiet outputs when no result
  p_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    !res_valid |-> (!res_hit && res_bank == '0 && res_data == '0));
endmodule

bind hier_cam_lookup hier_cam_lookup_chk #(.NB(NB), .DATA_W(DATA_W), .BANK_W(BANK_W)) u_chk (
  .clk(clk), .rst(rst), .srch_valid(srch_valid), .ins_valid(ins_valid),
  .ins_bank(ins_bank), .bank_full(bank_full), .res_valid(res_valid),
  .res_hit(res_hit), .res_bank(res_bank), .res_data(res_data), .ins_err(ins_err)
);

// File: tb/hier_cam_lookup_test.sv
`timescale 1ns/1ps
module hier_cam_lookup_test;
  localparam int NB = 3, DEPTH = 16, KW = 40, DW = 8;

  logic clk = 1'b0, rst = 1'b1;
  logic cfg_mask_we = 0, cfg_dflt_we = 0, ins_valid = 0, del_valid = 0, srch_valid = 0;
  logic [1:0] cfg_bank = 0, ins_bank = 0, del_bank = 0;
  logic [KW-1:0] cfg_mask = 0, ins_key = 0, del_key = 0, srch_key = 0;
  logic [DW-1:0] cfg_dflt = 0, ins_data = 0;
  logic res_valid, res_hit, ins_err;
  logic [1:0] res_bank;
  logic [DW-1:0] res_data;

  always #4 clk = ~clk;

  hier_cam_lookup uut (.*);

  int checks = 0, errors = 0;
  bit done = 0;

  // reference model
  bit            m_v [NB][DEPTH];
  logic [KW-1:0] m_k [NB][DEPTH];
  logic [DW-1:0] m_d [NB][DEPTH];
  logic [KW-1:0] m_mask [NB];
  logic [DW-1:0] m_dflt;

  // expected result of the search one step back
  bit            p_valid, p_hit;
  logic [1:0]    p_bank;
  logic [DW-1:0] p_data;
  string         p_tag, cur_tag;

  function automatic bit mfull(int b);
    for (int i = 0; i < DEPTH; i++) if (!m_v[b][i]) return 0;
    return 1;
  endfunction

  function automatic int mfree(int b);
    for (int i = 0; i < DEPTH; i++) if (!m_v[b][i]) return i;
    return -1;
  endfunction

  task automatic check(string tag, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int b = 0; b < NB; b++) begin
      m_mask[b] = '1;
      for (int i = 0; i < DEPTH; i++) m_v[b][i] = 0;
    end
    m_dflt = 0; p_valid = 0; p_hit = 0; p_bank = 0; p_data = 0; p_tag = "R1";
  endtask

  task automatic cycle();
    bit e_valid, e_hit, e_err; logic [1:0] e_bank; logic [DW-1:0] e_data;
    int slot;
    e_valid = srch_valid; e_hit = 0; e_bank = 0; e_data = m_dflt;
    if (srch_valid)
      for (int b = NB - 1; b >= 0; b--)
        for (int i = DEPTH - 1; i >= 0; i--)
          if (m_v[b][i] && (((m_k[b][i] ^ srch_key) & m_mask[b]) == 0)) begin
            e_hit = 1; e_bank = 2'(b); e_data = m_d[b][i];
          end
    if (!e_valid) e_data = 0;
    e_err = ins_valid && (ins_bank < NB) && mfull(ins_bank);
    slot = (ins_valid && ins_bank < NB) ? mfree(ins_bank) : -1;
    @(posedge clk); #1;
    // apply writes after the search used the old state
    if (del_valid && del_bank < NB)
      for (int i = 0; i < DEPTH; i++)
        if (m_v[del_bank][i] && (((m_k[del_bank][i] ^ del_key) & m_mask[del_bank]) == 0))
          m_v[del_bank][i] = 0;
    if (slot >= 0) begin
      m_v[ins_bank][slot] = 1; m_k[ins_bank][slot] = ins_key; m_d[ins_bank][slot] = ins_data;
    end
    if (cfg_mask_we && cfg_bank < NB) m_mask[cfg_bank] = cfg_mask;
    if (cfg_dflt_we) m_dflt = cfg_dflt;
    check("R7", "ins_err", 64'(ins_err), 64'(e_err));
    check(p_tag, "res_valid", 64'(res_valid), 64'(p_valid));
    check(p_tag, "res_hit", 64'(res_hit), 64'(p_hit));
    check(p_tag, "res_bank", 64'(res_bank), 64'(p_bank));
    check(p_tag, "res_data", 64'(res_data), 64'(p_data));
    p_valid = e_valid; p_hit = e_hit; p_bank = e_bank; p_data = e_data; p_tag = cur_tag;
    cfg_mask_we = 0; cfg_dflt_we = 0; ins_valid = 0; del_valid = 0; srch_valid = 0;
  endtask

  task automatic do_ins(int b, logic [KW-1:0] k, logic [DW-1:0] d);
    ins_valid = 1; ins_bank = 2'(b); ins_key = k; ins_data = d; cycle();
  endtask
  task automatic do_srch(string tag, logic [KW-1:0] k);
    cur_tag = tag; srch_valid = 1; srch_key = k; cycle(); cur_tag = "R10"; cycle();
  endtask

  localparam logic [KW-1:0] K  = 40'hA5_1234_5678;
  localparam logic [KW-1:0] K2 = 40'h3C_0F0F_0F0F;

  initial begin
    model_reset();
    cur_tag = "R1";
    repeat (3) @(posedge clk);
    #1 rst = 0;
    // R1: reset outputs, then empty banks give the zero default
    check("R1", "res_valid", 64'(res_valid), 0);
    check("R1", "ins_err", 64'(ins_err), 0);
    do_srch("R1", K);
    // R2: per-bank masks; default value
    cur_tag = "R10";
    cfg_mask_we = 1; cfg_bank = 0; cfg_mask = '1; cycle();
    cfg_mask_we = 1; cfg_bank = 1; cfg_mask = {24'hFFFFFF, 16'h0}; cycle();
    cfg_mask_we = 1; cfg_bank = 2; cfg_mask = {12'hFFF, 28'h0}; cycle();
    cfg_dflt_we = 1; cfg_dflt = 8'hA5; cycle();
    do_ins(2, K, 8'h30);
    do_ins(1, K, 8'h20);
    do_ins(0, K, 8'h10);
    do_srch("R4", K);                   // all three hit: bank 0
    do_srch("R2", K ^ 40'h1);           // bank 1 under its mask
    do_srch("R2", K ^ 40'h10_0000);     // only bank 2
    do_srch("R6", K ^ {1'b1, 39'h0});   // miss -> default
    // R5: two matching words in bank 1, lower slot wins
    do_ins(1, K ^ 40'h2, 8'h21);
    do_srch("R5", K ^ 40'h3);
    // R8: delete both bank 1 words, then reuse slot 0
    del_valid = 1; del_bank = 1; del_key = K ^ 40'h7; cycle();
    do_srch("R8", K ^ 40'h3);
    do_ins(1, K ^ 40'h8, 8'h22);
    do_srch("R8", K ^ 40'h3);
    // R9: insert and search of the same key in one cycle
    cur_tag = "R9";
    ins_valid = 1; ins_bank = 0; ins_key = K2; ins_data = 8'h11;
    srch_valid = 1; srch_key = K2; cycle();
    cur_tag = "R10"; cycle();
    do_srch("R9", K2);
    // R9: default change in the same cycle as a missing search
    cur_tag = "R9";
    cfg_dflt_we = 1; cfg_dflt = 8'h5A; srch_valid = 1; srch_key = 40'h0; cycle();
    cur_tag = "R10"; cycle();
    do_srch("R6", 40'h0);
    // R9: insert and delete to one bank at the same edge
    cur_tag = "R9";
    ins_valid = 1; ins_bank = 0; ins_key = K2 ^ 40'h1; ins_data = 8'h12;
    del_valid = 1; del_bank = 0; del_key = K2; cycle();
    do_srch("R9", K2 ^ 40'h1);
    do_srch("R9", K2);
    // R7: fill bank 2, then one more is rejected and absent
    for (int i = 1; i < DEPTH; i++) do_ins(2, 40'(i) << 28, 8'(8'h40 + i));
    do_ins(2, 40'hF << 36, 8'hEE);
    do_srch("R7", 40'hF << 36);
    // R3: random mix
    for (int n = 0; n < 3000; n++) begin
      int r;
      logic [KW-1:0] base;
      r = $urandom_range(0, 3);
      base = (r == 0) ? K : (r == 1) ? K2 : (r == 2) ? (40'h3 << 28) : 40'h0;
      cur_tag = "R3";
      if ($urandom_range(0, 2) == 0) begin
        ins_valid = 1; ins_bank = 2'($urandom_range(0, 3));
        ins_key = base ^ KW'($urandom_range(0, 15) << ($urandom_range(0, 9) * 4));
        ins_data = 8'($urandom);
      end
      if ($urandom_range(0, 5) == 0) begin
        del_valid = 1; del_bank = 2'($urandom_range(0, 2));
        del_key = base ^ KW'($urandom_range(0, 3));
      end
      if ($urandom_range(0, 19) == 0) begin
        cfg_dflt_we = 1; cfg_dflt = 8'($urandom);
      end
      if ($urandom_range(0, 3) != 0) begin
        srch_valid = 1;
        srch_key = base ^ KW'($urandom_range(0, 15) << ($urandom_range(0, 9) * 4));
      end
      cycle();
    end
    cur_tag = "R10";
    cycle(); cycle();
    done = 1;
  end

  initial begin
    void'($urandom(32'd5150));
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=done");
      end
    join_any
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule